// File: doc/BRIEF.md
# Nonvolatile Memory Access Controller

This block connects a small register bus from a processor to a data EEPROM array. Software uses four registers: a control register, an address register, a data register and an unlock register. The control register holds two target-select bits, a write-enable bit, an error flag and two start strobes. Software can set a strobe but cannot clear it; the hardware clears each strobe when its operation finishes.

A read finishes in one cycle. After that, the data register shows the addressed array word. It keeps that value until another read finishes or software writes the register. A write copies the address and data into the controller and then runs a programmable write timer. When the timer expires, the array is updated and a one-cycle done pulse is raised.

A write starts only after a two-step unlock sequence. The unlock register has no storage behind it. It only watches the bus-write stream for the two keys. If a reset arrives while a write is still running, a sticky error flag is set. A simple synchronous RAM and the write timer stand in for the real storage cells. Program and configuration space are only selected, not modelled: writes aimed at them run the timer but leave the array alone.

Top module: `nvm_ctrl`

## Requirements
- R1: The `target` output shows the selected space: 0 for data, 1 for program, 2 for configuration. Control bit 6 (configuration select) overrides control bit 7 (program select). When bit 6 is clear, bit 7 chooses between program (1) and data (0).
- R2: Register select codes are 0 control, 1 address, 2 data and 3 unlock. After reset, the control register reads 0x00, the data register reads 0x00 and `target` is 0. A bus read returns its value on the clock edge after `bus_re`.
- R3: Software starts a read by writing the control register with bit 0 (read strobe) set and both select bits clear. Exactly one cycle later, bit 0 reads back as 0 and the data register holds the array word at the address register.
- R4: A read request made with bit 7 or bit 6 set is refused. Bit 0 stays 0 and the data register is unchanged.
- R5: The data register keeps its value when the address changes. It changes only when a read finishes or software writes it.
- R6: The unlock register always reads as zero, whatever was written to it.
- R7: A write starts only if the two bus writes just before the control write were 0x55 and then 0xAA to the unlock register. Any other order, any missing key, or any other bus write in between leaves bit 1 at 0, raises no done pulse and leaves the array unchanged.
- R8: A write strobe (bit 1) is refused unless the same control write also sets bit 2 (write enable).
- R9: An accepted write keeps bit 1 at 1 for exactly WR_CYCLES cycles. `wr_done` pulses for one cycle as bit 1 clears, and the array holds the new word from then on. A control write with bit 1 clear cannot end the write early.
- R10: If reset arrives while bit 1 is 1, bit 3 (error) is set and stays set through the reset. Writing the control register with bit 3 at 0 clears it. Writing it with bit 3 at 1 never sets it.
- R11: A write started with program or configuration space selected runs the timer and pulses `wr_done`, but does not change the data array.
- R12: A read request made while a write is in progress is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_sel | input | 2 | Register select |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Registered read data |
| target | output | 2 | Currently selected space |
| wr_done | output | 1 | One-cycle pulse when a write completes |

## Verification
Reads are tried against two array words written with different values. This shows that the data register follows the address given at the moment of the read, not a stale one. Unlock streams are varied: the right order, swapped keys, a missing first key, and an address write placed between the keys. Each is weighed by whether the done pulse appears and whether the stored word changes. Write attempts are also sent to each of the three target spaces and with write enable clear, to separate a refused write from a timed write that has no array effect. A reset in the middle of a write checks that the error flag is set, that the array is left untouched, and that the flag can only be cleared by software.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_DATA = 2'd2,
    SEL_UNLK = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    TGT_DATA = 2'd0,
    TGT_PROG = 2'd1,
    TGT_CFG  = 2'd2
  } target_e;

  typedef enum logic [1:0] {
    UL_IDLE = 2'd0,
    UL_HALF = 2'd1,
    UL_OPEN = 2'd2
  } unlock_e;

  localparam int B_RD   = 0;
  localparam int B_WR   = 1;
  localparam int B_WEN  = 2;
  localparam int B_ERR  = 3;
  localparam int B_CSEL = 6;
  localparam int B_PSEL = 7;

  function automatic target_e pick_target(logic psel, logic csel);
    if (csel) return TGT_CFG;
    if (psel) return TGT_PROG;
    return TGT_DATA;
  endfunction

endpackage

// File: rtl/nvm_unlock.sv
module nvm_unlock
  import nvm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] KEY_A = 'h55,
  parameter logic [DATA_W-1:0] KEY_B = 'hAA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              to_unlk,
  input  logic [DATA_W-1:0] wdata,
  output logic              armed
);

  unlock_e state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= UL_IDLE;
    end else if (bus_we) begin
      if (to_unlk && wdata == KEY_A)
        state_q <= UL_HALF;
      else if (to_unlk && wdata == KEY_B && state_q == UL_HALF)
        state_q <= UL_OPEN;
      else
        state_q <= UL_IDLE;
    end
  end

  assign armed = (state_q == UL_OPEN);

endmodule

// File: rtl/nvm_wtimer.sv
module nvm_wtimer #(
  parameter int WR_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic fire,
  output logic done
);

  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q = 1'b0;
  logic             done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= fire;
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(WR_CYCLES - 1);
      end else if (busy_q) begin
        if (cnt_q == '0) busy_q <= 1'b0;
        else             cnt_q  <= cnt_q - 1'b1;
      end
    end
  end

  assign busy = busy_q;
  assign fire = busy_q && (cnt_q == '0);
  assign done = done_q;

endmodule

// File: rtl/nvm_array.sv
module nvm_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
  import nvm_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int WR_CYCLES = 16,
  parameter logic [DATA_W-1:0] KEY_A = 'h55,
  parameter logic [DATA_W-1:0] KEY_B = 'hAA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [1:0]        bus_sel,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [1:0]        target,
  output logic              wr_done
);

  reg_sel_e sel;
  logic wr_ctrl, wr_addr, wr_data, wr_unlk;
  logic armed, wr_start, rd_ok;
  logic wr_busy, wr_fire;

  logic              psel_q, csel_q, wen_q, rd_q;
  logic              err_q = 1'b0;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] dsw_q;
  logic              dsrc_q;
  logic [DATA_W-1:0] rdata_q;
  logic [ADDR_W-1:0] wa_q;
  logic [DATA_W-1:0] wd_q;
  target_e           wtgt_q;

  logic [DATA_W-1:0] arr_dout, data_eff, ctrl_word, addr_word;

  assign sel     = reg_sel_e'(bus_sel);
  assign wr_ctrl = bus_we && (sel == SEL_CTRL);
  assign wr_addr = bus_we && (sel == SEL_ADDR);
  assign wr_data = bus_we && (sel == SEL_DATA);
  assign wr_unlk = bus_we && (sel == SEL_UNLK);

  nvm_unlock #(.DATA_W(DATA_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_unlock (
    .clk(clk), .rst(rst), .bus_we(bus_we), .to_unlk(wr_unlk),
    .wdata(bus_wdata), .armed(armed)
  );

  assign wr_start = wr_ctrl && bus_wdata[B_WR] && bus_wdata[B_WEN] &&
                    armed && !wr_busy;
  assign rd_ok    = wr_ctrl && bus_wdata[B_RD] && !bus_wdata[B_PSEL] &&
                    !bus_wdata[B_CSEL] && !wr_busy && !wr_start && !rd_q;

  nvm_wtimer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(wr_start),
    .busy(wr_busy), .fire(wr_fire), .done(wr_done)
  );

  nvm_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .we(wr_fire && (wtgt_q == TGT_DATA)), .waddr(wa_q),
    .wdata(wd_q), .re(rd_q), .raddr(addr_q), .rdata(arr_dout)
  );

  // control fields, address and read strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      psel_q <= 1'b0;
      csel_q <= 1'b0;
      wen_q  <= 1'b0;
      rd_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      rd_q <= rd_ok;
      if (wr_ctrl) begin
        psel_q <= bus_wdata[B_PSEL];
        csel_q <= bus_wdata[B_CSEL];
        wen_q  <= bus_wdata[B_WEN];
      end
      if (wr_addr) addr_q <= bus_wdata[ADDR_W-1:0];
    end
  end

  // sticky error: survives reset, cleared only by software
  always_ff @(posedge clk) begin
    if (rst)                               err_q <= err_q | wr_busy;
    else if (wr_ctrl && !bus_wdata[B_ERR]) err_q <= 1'b0;
  end

  // data register: software copy or last array read
  always_ff @(posedge clk) begin
    if (rst) begin
      dsw_q  <= '0;
      dsrc_q <= 1'b0;
    end else if (wr_data) begin
      dsw_q  <= bus_wdata;
      dsrc_q <= 1'b0;
    end else if (rd_q) begin
      dsrc_q <= 1'b1;
    end
  end

  assign data_eff = dsrc_q ? arr_dout : dsw_q;

  // write operands captured at start
  always_ff @(posedge clk) begin
    if (rst) begin
      wa_q   <= '0;
      wd_q   <= '0;
      wtgt_q <= TGT_DATA;
    end else if (wr_start) begin
      wa_q   <= addr_q;
      wd_q   <= data_eff;
      wtgt_q <= pick_target(bus_wdata[B_PSEL], bus_wdata[B_CSEL]);
    end
  end

  always_comb begin
    ctrl_word         = '0;
    ctrl_word[B_PSEL] = psel_q;
    ctrl_word[B_CSEL] = csel_q;
    ctrl_word[B_ERR]  = err_q;
    ctrl_word[B_WEN]  = wen_q;
    ctrl_word[B_WR]   = wr_busy;
    ctrl_word[B_RD]   = rd_q;
    addr_word               = '0;
    addr_word[ADDR_W-1:0]   = addr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_re) begin
      case (sel)
        SEL_CTRL: rdata_q <= ctrl_word;
        SEL_ADDR: rdata_q <= addr_word;
        SEL_DATA: rdata_q <= data_eff;
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign target    = pick_target(psel_q, csel_q);

endmodule

// File: rtl/nvm_ctrl_chk.sv
module nvm_ctrl_chk
  import nvm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_re,
  input logic [1:0]        bus_sel,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              wr_done,
  input logic              wr_bit,
  input logic              rd_bit,
  input logic              wen_bit
);

  // R6
  unlk_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_re && bus_sel == SEL_UNLK) |=> (bus_rdata == '0));

  // R9
  done_end_chk: assert property (@(posedge clk) disable iff (rst)
    wr_done |-> (!wr_bit && $past(wr_bit)));

  // R3
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_bit |=> !rd_bit);

  // R12
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    wr_bit |-> !rd_bit);

  // R8
  wen_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_bit) |-> wen_bit);

  // R2
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!wr_bit && !rd_bit && !wen_bit));

endmodule

bind nvm_ctrl nvm_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .bus_re(bus_re), .bus_sel(bus_sel),
  .bus_rdata(bus_rdata), .wr_done(wr_done), .wr_bit(wr_busy),
  .rd_bit(rd_q), .wen_bit(wen_q)
);

// File: tb/nvm_ctrl_bench.sv
module nvm_ctrl_bench;

  localparam int W = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_we = 1'b0;
  logic       bus_re = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic [1:0] target;
  logic       wr_done;

  int n_vec = 0;
  int n_bad = 0;
  int done_cnt = 0;
  logic re_seen = 1'b0;
  bit finished = 1'b0;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  nvm_ctrl #(.ADDR_W(8), .DATA_W(8), .WR_CYCLES(W)) u_nvm_ctrl (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .target(target), .wr_done(wr_done)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    re_seen <= bus_re;
    if (wr_done) done_cnt <= done_cnt + 1;
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // monitor: compare each read result against the scoreboard
  always @(negedge clk) begin
    if (re_seen && !finished) begin
      if (exp_q.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL scoreboard: actual %02h expected none", bus_rdata);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag, bus_rdata, e.val);
      end
    end
  end

  task automatic bw(logic [1:0] s, logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_sel = s; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic br(logic [1:0] s, logic [7:0] v, string tag);
    exp_t e;
    e.val = v; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    bus_re = 1'b1; bus_sel = s;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic unlock();
    bw(2'd3, 8'h55);
    bw(2'd3, 8'hAA);
  endtask

  task automatic wait_done(string tag);
    int start;
    bit seen;
    start = done_cnt;
    seen = 1'b0;
    for (int i = 0; i < W + 8; i++) begin
      @(negedge clk);
      if (done_cnt != start) begin seen = 1'b1; break; end
    end
    check(tag, 8'(seen), 8'd1);
  endtask

  task automatic read_mem(logic [7:0] a, logic [7:0] v, string tag);
    bw(2'd2, 8'h00);
    bw(2'd1, a);
    bw(2'd0, 8'h01);
    idle(1);
    br(2'd2, v, tag);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int base;
    idle(4);
    rst = 1'b0;

    // R2 reset state
    check("R2 target", {6'd0, target}, 8'h00);
    br(2'd0, 8'h00, "R2 ctrl");
    br(2'd2, 8'h00, "R2 data");

    // R6 unlock reads zero
    bw(2'd3, 8'h55);
    br(2'd3, 8'h00, "R6 after key");
    bw(2'd3, 8'hFF);
    br(2'd3, 8'h00, "R6 after ff");

    // R1 select priority
    bw(2'd0, 8'h80); check("R1 prog", {6'd0, target}, 8'h01);
    bw(2'd0, 8'h40); check("R1 cfg", {6'd0, target}, 8'h02);
    bw(2'd0, 8'hC0); check("R1 both", {6'd0, target}, 8'h02);
    br(2'd0, 8'hC0, "R1 readback");
    bw(2'd0, 8'h00); check("R1 data", {6'd0, target}, 8'h00);

    // R9 exact write timing at 0x12
    bw(2'd1, 8'h12);
    bw(2'd2, 8'hA5);
    unlock();
    bw(2'd0, 8'h06);
    for (int i = 1; i < W; i++) begin
      @(negedge clk);
      check("R9 no early done", {7'd0, wr_done}, 8'h00);
    end
    @(negedge clk);
    check("R9 done pulse", {7'd0, wr_done}, 8'h01);
    @(negedge clk);
    check("R9 done single", {7'd0, wr_done}, 8'h00);
    br(2'd0, 8'h04, "R9 strobe cleared");

    // R9 / R12 software cannot stop a write; reads refused while busy
    bw(2'd1, 8'h34);
    bw(2'd2, 8'h5A);
    unlock();
    bw(2'd0, 8'h06);
    br(2'd0, 8'h06, "R9 busy");
    bw(2'd0, 8'h04);
    br(2'd0, 8'h06, "R9 not cleared by sw");
    bw(2'd0, 8'h05);
    br(2'd0, 8'h06, "R12 rd refused");
    br(2'd2, 8'h5A, "R12 data unchanged");
    wait_done("R9 second write done");

    // R3 reads of two locations
    read_mem(8'h12, 8'hA5, "R3 read 12");
    br(2'd0, 8'h00, "R3 strobe cleared");
    read_mem(8'h34, 8'h5A, "R3 read 34");

    // R5 retention
    bw(2'd1, 8'h12);
    br(2'd2, 8'h5A, "R5 addr change");
    bw(2'd2, 8'h3C);
    br(2'd2, 8'h3C, "R5 sw write");

    // R4 refused reads with a select set
    bw(2'd0, 8'h81);
    idle(1);
    br(2'd0, 8'h80, "R4 prog rd bit");
    br(2'd2, 8'h3C, "R4 prog data");
    bw(2'd0, 8'h41);
    idle(1);
    br(2'd0, 8'h40, "R4 cfg rd bit");
    br(2'd2, 8'h3C, "R4 cfg data");

    // R7 broken unlock sequences
    base = done_cnt;
    bw(2'd0, 8'h00);
    bw(2'd1, 8'h12);
    bw(2'd2, 8'h77);
    bw(2'd0, 8'h06);
    br(2'd0, 8'h04, "R7 no unlock");
    bw(2'd3, 8'hAA); bw(2'd3, 8'h55); bw(2'd0, 8'h06);
    br(2'd0, 8'h04, "R7 swapped keys");
    bw(2'd3, 8'h55); bw(2'd1, 8'h12); bw(2'd3, 8'hAA); bw(2'd0, 8'h06);
    br(2'd0, 8'h04, "R7 interrupted");
    bw(2'd3, 8'hAA); bw(2'd0, 8'h06);
    br(2'd0, 8'h04, "R7 second key only");
    idle(W + 4);
    check("R7 no done", 8'(done_cnt - base), 8'h00);
    read_mem(8'h12, 8'hA5, "R7 array kept");

    // R8 write enable required
    base = done_cnt;
    bw(2'd1, 8'h12);
    bw(2'd2, 8'h66);
    unlock();
    bw(2'd0, 8'h02);
    br(2'd0, 8'h00, "R8 wr refused");
    idle(W + 4);
    check("R8 no done", 8'(done_cnt - base), 8'h00);
    read_mem(8'h12, 8'hA5, "R8 array kept");

    // R11 program and configuration targets
    bw(2'd1, 8'h12);
    bw(2'd2, 8'h99);
    unlock();
    bw(2'd0, 8'h86);
    wait_done("R11 prog done");
    bw(2'd2, 8'h98);
    unlock();
    bw(2'd0, 8'h46);
    wait_done("R11 cfg done");
    read_mem(8'h12, 8'hA5, "R11 array kept");

    // R10 reset during a write
    bw(2'd1, 8'h12);
    bw(2'd2, 8'hEE);
    unlock();
    bw(2'd0, 8'h06);
    idle(3);
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    br(2'd0, 8'h08, "R10 err set");
    bw(2'd0, 8'h08);
    br(2'd0, 8'h08, "R10 err kept");
    bw(2'd0, 8'h00);
    br(2'd0, 8'h00, "R10 err cleared");
    bw(2'd0, 8'h08);
    br(2'd0, 8'h00, "R10 err not set by sw");
    read_mem(8'h12, 8'hA5, "R10 array kept");

    idle(4);
    if (exp_q.size() != 0) begin
      n_vec++; n_bad++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    finish_run();
  end

endmodule